// File: doc/BRIEF.md
# SDRAM Refresh and Power-Mode Scheduler

This block sits on the controller side of an SDRAM interface. It keeps the memory refreshed and walks it in and out of its clock-enable low-power modes. A free-running interval counter builds up a refresh debt: one auto refresh is owed every `REF_INTERVAL` clocks. The default of 1950 clocks is 15.6 µs at 125 MHz, which spreads 4096 refreshes over 64 ms. While it owes a refresh, or while the host asks for self refresh or power down, the scheduler requests the command bus from the main arbiter. It keeps that request up until the arbiter grants the bus and reports all banks precharged. Only then does it drive a command.

A refresh command is a one-cycle pulse on `cmd_aref_o` with `cke_o` high, followed by a fixed window of no commands. Self-refresh entry is a one-cycle pulse on `cmd_sref_o` in the same cycle that `cke_o` falls. The device stays in that state for a minimum residence time and then exits through a mandatory no-command window. Power down simply drops `cke_o`. The scheduler forces a power-down exit when the debt reaches its postponement limit, because the device does not refresh itself in that mode. If the debt ever goes past the limit, `overdue_o` rises. Every owed refresh, and never fewer than two, is then issued back to back before any low-power mode is granted.

Top module: `sdram_refresh_pm_sched`

## Requirements
- R1: After a synchronous reset, `cke_o` is 1, and `arb_req_o`, `need_idle_o`, `cmd_aref_o`, `cmd_sref_o` and `overdue_o` are 0.
- R2: The interval counter adds one owed refresh when it expires, and it expires every `REF_INTERVAL` cycles, the first time `REF_INTERVAL` cycles after reset is released. The scheduler is idle when the debt rises, so `arb_req_o` rises one cycle later.
- R3: While it waits, the scheduler holds `arb_req_o` and `need_idle_o` high. It issues no command until it has seen `arb_gnt_i` and `banks_idle_i` both high in the same cycle. The command follows in the next cycle.
- R4: An auto refresh is `cmd_aref_o` high for exactly one cycle with `cke_o` high, and it reduces the debt by one. It is followed by `T_RFC` cycles with both command outputs low while `arb_req_o` stays high.
- R5: When the debt would exceed `MAX_POSTPONE`, it saturates at `MAX_POSTPONE`+1 and `overdue_o` rises. `overdue_o` falls only once the debt is back at zero, which takes at least two refreshes issued back to back.
- R6: With no debt, a granted self-refresh request drives `cmd_sref_o` high for one cycle, and `cke_o` falls in that same cycle. Owed refreshes are always issued before self refresh or power down is entered.
- R7: Once self refresh has been entered, `cke_o` stays low for at least 1+`T_SR_MIN` cycles, even if the self-refresh request is withdrawn at once.
- R8: When self refresh ends, `cke_o` rises and stays high. No command follows for `T_RFC` cycles.
- R9: No refresh debt builds up while `cke_o` is low in self refresh.
- R10: A granted power-down request with no debt drops `cke_o` without any command. When the request is withdrawn, `cke_o` rises and one further cycle passes with no command before the bus is released.
- R11: When the debt reaches `MAX_POSTPONE` during power down, the scheduler leaves power down and refreshes, even though the power-down request is still held.
- R12: If every request disappears before the grant, `arb_req_o` and `need_idle_o` drop without any command being issued.
- R13: `cmd_aref_o` and `cmd_sref_o` are never high together. `arb_req_o` is high whenever `cke_o` is low or `overdue_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_self_i | input | 1 | Host asks for self refresh (level) |
| lp_pdown_i | input | 1 | Host asks for power down (level) |
| arb_gnt_i | input | 1 | Arbiter grants the command bus |
| banks_idle_i | input | 1 | Arbiter reports all banks precharged |
| arb_req_o | output | 1 | Request for, and ownership of, the command bus |
| need_idle_o | output | 1 | All banks must be precharged before the scheduler proceeds |
| cke_o | output | 1 | Clock enable to the SDRAM |
| cmd_aref_o | output | 1 | Drive the refresh command with clock enable high |
| cmd_sref_o | output | 1 | Drive the refresh command with clock enable low (self-refresh entry) |
| overdue_o | output | 1 | Refresh debt has exceeded the postponement limit |

## Verification
The hardest state to reach from the ports is the overrun: the debt has to climb past its limit and then be repaid in one back-to-back burst. The bench gets there by withholding the grant for several full intervals, which saturates the debt, and then granting continuously so the burst can be counted. The forced power-down exit is reached by holding the power-down request across several intervals. The minimum self-refresh residence is exposed by withdrawing the request in the cycle after the entry pulse is seen.

// File: rtl/sdr_pm_pkg.sv
package sdr_pm_pkg;

    typedef enum logic [3:0] {
        PM_IDLE,
        PM_REQ,
        PM_REF,
        PM_RFC,
        PM_SR_IN,
        PM_SR,
        PM_SR_OUT,
        PM_PD,
        PM_PD_OUT
    } pm_state_e;

    typedef struct packed {
        logic cke;
        logic arb_req;
        logic need_idle;
        logic do_ref;
        logic do_sref;
    } pm_drive_t;

    function automatic pm_drive_t drive_of(pm_state_e s);
        pm_drive_t d;
        d.cke       = 1'b1;
        d.arb_req   = 1'b1;
        d.need_idle = 1'b0;
        d.do_ref    = 1'b0;
        d.do_sref   = 1'b0;
        unique case (s)
            PM_IDLE:  d.arb_req   = 1'b0;
            PM_REQ:   d.need_idle = 1'b1;
            PM_REF:   d.do_ref    = 1'b1;
            PM_SR_IN: begin
                d.do_sref = 1'b1;
                d.cke     = 1'b0;
            end
            PM_SR:    d.cke = 1'b0;
            PM_PD:    d.cke = 1'b0;
            default:  ;
        endcase
        return d;
    endfunction

    function automatic logic in_self_refresh(pm_state_e s);
        return (s == PM_SR_IN) || (s == PM_SR);
    endfunction

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
    parameter int INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    assign tick_o = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)         cnt <= RELOAD;
        else if (tick_o) cnt <= RELOAD;
        else             cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/refresh_debt_ctr.sv
module refresh_debt_ctr #(
    parameter int MAX_POSTPONE = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic hold_i,
    input  logic paid_i,
    output logic debt_nz_o,
    output logic at_limit_o,
    output logic overdue_o
);
    localparam int LIMIT = MAX_POSTPONE + 1;
    localparam int DW    = $clog2(LIMIT + 1);
    localparam logic [DW-1:0] LIM_V = DW'(LIMIT);
    localparam logic [DW-1:0] MAX_V = DW'(MAX_POSTPONE);

    logic [DW-1:0] debt, debt_n;
    logic          ovd, ovd_n;
    logic          up;

    always_comb begin
        up     = tick_i && !hold_i && (debt != LIM_V);
        debt_n = debt;
        if (up)     debt_n = debt_n + 1'b1;
        if (paid_i) debt_n = debt_n - 1'b1;
        if (debt_n == LIM_V)   ovd_n = 1'b1;
        else if (debt_n == '0) ovd_n = 1'b0;
        else                   ovd_n = ovd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            debt <= '0;
            ovd  <= 1'b0;
        end else begin
            debt <= debt_n;
            ovd  <= ovd_n;
        end
    end

    assign debt_nz_o  = (debt != '0);
    assign at_limit_o = (debt >= MAX_V);
    assign overdue_o  = ovd;
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
    import sdr_pm_pkg::*;
#(
    parameter int T_RFC    = 9,
    parameter int T_SR_MIN = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      self_i,
    input  logic      pdown_i,
    input  logic      gnt_i,
    input  logic      idle_i,
    input  logic      debt_nz_i,
    input  logic      at_limit_i,
    output pm_state_e state_o
);
    localparam int TMAX = (T_RFC > T_SR_MIN) ? T_RFC : T_SR_MIN;
    localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam logic [TW-1:0] RFC_LOAD   = TW'(T_RFC - 1);
    localparam logic [TW-1:0] SRMIN_LOAD = TW'(T_SR_MIN - 1);

    pm_state_e     st, st_n;
    logic [TW-1:0] tmr, tmr_n;
    logic          work;

    always_comb begin
        st_n  = st;
        tmr_n = tmr;
        work  = debt_nz_i || self_i || pdown_i;
        unique case (st)
            PM_IDLE: if (work) st_n = PM_REQ;
            PM_REQ: begin
                if (gnt_i && idle_i) begin
                    if (debt_nz_i)    st_n = PM_REF;
                    else if (self_i)  st_n = PM_SR_IN;
                    else if (pdown_i) st_n = PM_PD;
                    else              st_n = PM_IDLE;
                end else if (!work) begin
                    st_n = PM_IDLE;
                end
            end
            PM_REF: begin
                st_n  = PM_RFC;
                tmr_n = RFC_LOAD;
            end
            PM_RFC, PM_SR_OUT: begin
                if (tmr == '0) st_n = work ? PM_REQ : PM_IDLE;
                else           tmr_n = tmr - 1'b1;
            end
            PM_SR_IN: begin
                st_n  = PM_SR;
                tmr_n = SRMIN_LOAD;
            end
            PM_SR: begin
                if (tmr != '0) begin
                    tmr_n = tmr - 1'b1;
                end else if (!self_i) begin
                    st_n  = PM_SR_OUT;
                    tmr_n = RFC_LOAD;
                end
            end
            PM_PD:     if (!pdown_i || at_limit_i) st_n = PM_PD_OUT;
            PM_PD_OUT: st_n = work ? PM_REQ : PM_IDLE;
            default:   st_n = PM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PM_IDLE;
            tmr <= '0;
        end else begin
            st  <= st_n;
            tmr <= tmr_n;
        end
    end

    assign state_o = st;
endmodule

// File: rtl/sdram_refresh_pm_sched.sv
module sdram_refresh_pm_sched
    import sdr_pm_pkg::*;
#(
    parameter int REF_INTERVAL = 1950,
    parameter int MAX_POSTPONE = 8,
    parameter int T_RFC        = 9,
    parameter int T_SR_MIN     = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_self_i,
    input  logic lp_pdown_i,
    input  logic arb_gnt_i,
    input  logic banks_idle_i,
    output logic arb_req_o,
    output logic need_idle_o,
    output logic cke_o,
    output logic cmd_aref_o,
    output logic cmd_sref_o,
    output logic overdue_o
);
    logic      tick;
    logic      debt_nz, at_limit;
    pm_state_e st;
    pm_drive_t drv;

    assign drv = drive_of(st);

    refresh_tick_gen #(.INTERVAL(REF_INTERVAL)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    refresh_debt_ctr #(.MAX_POSTPONE(MAX_POSTPONE)) u_debt (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .hold_i     (in_self_refresh(st)),
        .paid_i     (drv.do_ref),
        .debt_nz_o  (debt_nz),
        .at_limit_o (at_limit),
        .overdue_o  (overdue_o)
    );

    pm_sequencer #(.T_RFC(T_RFC), .T_SR_MIN(T_SR_MIN)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .self_i     (lp_self_i),
        .pdown_i    (lp_pdown_i),
        .gnt_i      (arb_gnt_i),
        .idle_i     (banks_idle_i),
        .debt_nz_i  (debt_nz),
        .at_limit_i (at_limit),
        .state_o    (st)
    );

    assign arb_req_o   = drv.arb_req;
    assign need_idle_o = drv.need_idle;
    assign cke_o       = drv.cke;
    assign cmd_aref_o  = drv.do_ref;
    assign cmd_sref_o  = drv.do_sref;
endmodule

// File: rtl/sdram_refresh_pm_sched_chk.sv
module sdram_refresh_pm_sched_chk (
    input logic clk,
    input logic rst,
    input logic arb_gnt_i,
    input logic banks_idle_i,
    input logic arb_req_o,
    input logic cke_o,
    input logic cmd_aref_o,
    input logic cmd_sref_o,
    input logic overdue_o
);
    // R13
    cmd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_aref_o, cmd_sref_o}));

    // R13
    cke_low_owned_chk: assert property (@(posedge clk) disable iff (rst)
        !cke_o |-> arb_req_o);

    // R13
    overdue_owned_chk: assert property (@(posedge clk) disable iff (rst)
        overdue_o |-> arb_req_o);

    // R3
    cmd_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_aref_o || cmd_sref_o) |-> $past(arb_gnt_i && banks_idle_i));

    // R4
    aref_cke_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_aref_o |-> (cke_o && $past(cke_o)));

    // R4
    aref_gap_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_aref_o |=> (!cmd_aref_o && !cmd_sref_o && arb_req_o));

    // R6
    sref_entry_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_sref_o |-> (!cke_o && $past(cke_o)));

    // R8
    exit_nop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_o) |-> (!cmd_aref_o && !cmd_sref_o));
endmodule

bind sdram_refresh_pm_sched sdram_refresh_pm_sched_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .arb_gnt_i    (arb_gnt_i),
    .banks_idle_i (banks_idle_i),
    .arb_req_o    (arb_req_o),
    .cke_o        (cke_o),
    .cmd_aref_o   (cmd_aref_o),
    .cmd_sref_o   (cmd_sref_o),
    .overdue_o    (overdue_o)
);

// File: tb/sdram_refresh_pm_sched_tb_top.sv
`timescale 1ns/1ps
module sdram_refresh_pm_sched_tb_top;
    localparam int INTERVAL = 40;
    localparam int MAXP     = 3;
    localparam int TRFC     = 5;
    localparam int TSRMIN   = 4;
    localparam int LIM      = MAXP + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sr = 1'b0, pd = 1'b0, gnt = 1'b0, bidle = 1'b0;
    logic arb_req, need_idle, cke, aref, sref, ovd;

    always #2 clk = ~clk;

    sdram_refresh_pm_sched #(
        .REF_INTERVAL(INTERVAL), .MAX_POSTPONE(MAXP),
        .T_RFC(TRFC), .T_SR_MIN(TSRMIN)
    ) dut_i (
        .clk(clk), .rst(rst), .lp_self_i(sr), .lp_pdown_i(pd),
        .arb_gnt_i(gnt), .banks_idle_i(bidle),
        .arb_req_o(arb_req), .need_idle_o(need_idle), .cke_o(cke),
        .cmd_aref_o(aref), .cmd_sref_o(sref), .overdue_o(ovd)
    );

    int n_vec = 0;
    int n_bad = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    // Reference model: phases as integers
    localparam int P_IDLE = 0, P_WAIT = 1, P_REF = 2, P_GAP = 3, P_SIN = 4,
                   P_SELF = 5, P_SOUT = 6, P_PD = 7, P_PDX = 8;
    int m_cnt, m_debt, m_phase, m_left;
    bit m_ovd;
    int nx_cnt, nx_debt, nx_phase, nx_left;
    bit nx_ovd, owed, busy;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= INTERVAL - 1; m_debt <= 0; m_phase <= P_IDLE;
            m_left <= 0; m_ovd <= 1'b0;
        end else begin
            owed    = (m_cnt == 0) && !(m_phase == P_SIN || m_phase == P_SELF);
            nx_cnt  = (m_cnt == 0) ? INTERVAL - 1 : m_cnt - 1;
            nx_debt = m_debt;
            if (owed && m_debt < LIM) nx_debt++;
            if (m_phase == P_REF) nx_debt--;
            nx_ovd  = (nx_debt == LIM) ? 1'b1 : ((nx_debt == 0) ? 1'b0 : m_ovd);
            busy    = (m_debt > 0) || sr || pd;
            nx_phase = m_phase;
            nx_left  = m_left;
            case (m_phase)
                P_IDLE: if (busy) nx_phase = P_WAIT;
                P_WAIT:
                    if (gnt && bidle)
                        nx_phase = (m_debt > 0) ? P_REF : sr ? P_SIN : pd ? P_PD : P_IDLE;
                    else if (!busy) nx_phase = P_IDLE;
                P_REF: begin nx_phase = P_GAP; nx_left = TRFC - 1; end
                P_GAP, P_SOUT:
                    if (m_left == 0) nx_phase = busy ? P_WAIT : P_IDLE;
                    else nx_left = m_left - 1;
                P_SIN: begin nx_phase = P_SELF; nx_left = TSRMIN - 1; end
                P_SELF:
                    if (m_left != 0) nx_left = m_left - 1;
                    else if (!sr) begin nx_phase = P_SOUT; nx_left = TRFC - 1; end
                P_PD: if (!pd || m_debt >= MAXP) nx_phase = P_PDX;
                P_PDX: nx_phase = busy ? P_WAIT : P_IDLE;
                default: nx_phase = P_IDLE;
            endcase
            m_cnt <= nx_cnt; m_debt <= nx_debt; m_ovd <= nx_ovd;
            m_phase <= nx_phase; m_left <= nx_left;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            check(cke == !(m_phase == P_SIN || m_phase == P_SELF || m_phase == P_PD),
                  "cke_o", cke, !(m_phase == P_SIN || m_phase == P_SELF || m_phase == P_PD));
            check(arb_req == (m_phase != P_IDLE), "arb_req_o", arb_req, m_phase != P_IDLE);
            check(need_idle == (m_phase == P_WAIT), "need_idle_o", need_idle, m_phase == P_WAIT);
            check(aref == (m_phase == P_REF), "cmd_aref_o", aref, m_phase == P_REF);
            check(sref == (m_phase == P_SIN), "cmd_sref_o", sref, m_phase == P_SIN);
            check(ovd == m_ovd, "overdue_o", ovd, m_ovd);
            // R13 exclusivity and ownership
            check(!(aref && sref) && (cke || arb_req), "R13 cmd/ownership", {aref, sref}, 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sample();
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        step(5);
        rst = 1'b0;
        // R1: reset values
        cur_tag = "R1";
        sample();
        check(cke && !arb_req && !need_idle && !aref && !sref && !ovd,
              "R1 reset outputs", {cke, arb_req, need_idle, aref, sref, ovd}, 6'b100000);
        @(negedge clk);
        // R2: periodic refresh with free grant
        cur_tag = "R2";
        gnt = 1'b1; bidle = 1'b1;
        step(130);
        // R3: grant without idle, idle without grant
        cur_tag = "R3";
        gnt = 1'b0; step(60);
        gnt = 1'b1; bidle = 1'b0; step(30);
        bidle = 1'b1; step(20);
        // R4: refresh pulses and gaps
        cur_tag = "R4";
        step(50);
        // R5: overrun then catch-up burst
        cur_tag = "R5";
        gnt = 1'b0; step(200);
        sample();
        check(ovd == 1'b1, "R5 overdue raised", ovd, 1);
        @(negedge clk);
        gnt = 1'b1;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            sample();
            if (aref) cnt++;
            if (!ovd) break;
        end
        check(cnt >= 2, "R5 catch-up refresh count", cnt, 2);
        @(negedge clk);
        step(20);
        // R6 / R9: self refresh held across many intervals
        cur_tag = "R6";
        sr = 1'b1; step(20);
        sample();
        check(cke == 1'b0, "R6 cke low in self refresh", cke, 0);
        @(negedge clk);
        cur_tag = "R9";
        step(200);
        // R8: exit window
        cur_tag = "R8";
        sr = 1'b0; step(30);
        // R7: minimum residence
        cur_tag = "R7";
        step(10);
        sr = 1'b1;
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            sample();
            if (sref) break;
        end
        @(negedge clk);
        sr = 1'b0;
        cnt = 1;
        for (int i = 0; i < 40; i++) begin
            sample();
            if (!cke) cnt++;
            else break;
        end
        check(cnt >= 1 + TSRMIN, "R7 self-refresh residence", cnt, 1 + TSRMIN);
        @(negedge clk);
        step(20);
        // R10: power down enter and exit
        cur_tag = "R10";
        pd = 1'b1; step(20);
        pd = 1'b0; step(10);
        // R11: forced exits while held
        cur_tag = "R11";
        pd = 1'b1;
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            sample();
            if (aref) cnt++;
        end
        check(cnt >= 3, "R11 refreshes during held power down", cnt, 3);
        @(negedge clk);
        pd = 1'b0; step(10);
        // R12: request withdrawn before grant
        cur_tag = "R12";
        for (int i = 0; i < 100; i++) begin
            sample();
            if (aref) break;
        end
        @(negedge clk);
        step(TRFC + 3);
        gnt = 1'b0; sr = 1'b1; step(3);
        sr = 1'b0; step(3);
        sample();
        check(!arb_req && !need_idle, "R12 request dropped", {arb_req, need_idle}, 0);
        @(negedge clk);
        step(5);
        finish_run();
    end
endmodule